// File: doc/BRIEF.md
# Block Storage Device Controller

This block stands in front of a small block-organised storage array and makes it look like a handful of registers in the processor's address space. Software chooses a block and a system-memory address, then writes a command. The block then copies one whole block in one direction: from the array out to system memory, or from system memory into the array. Software never reaches individual storage words; every access moves an entire block.

The copy runs through a word-wide master port that uses a valid/ready handshake. The block drives `mem_valid` together with the address, direction and (for stores to memory) the data. It holds all of them unchanged until `mem_ready` is sampled high. Exactly one word moves on each clock edge where both are high. Back-pressure may last any number of cycles. On loads from memory, `mem_rdata` must be valid in the same cycle as the accepting handshake.

When the last word has moved, the block raises `irq`. The line stays high until software writes the acknowledge register. Reading status does not clear it. A status register reports busy, done and error conditions.

Top module: `blk_store_ctrl`

## Requirements
- R1: After reset the status register reads 0, `irq` is low and `mem_valid` is low.
- R2: While idle, writes to offset 0x0 (block number, 8 bits) and offset 0x4 (memory base address) are stored and read back at the same offsets.
- R3: Writing offset 0x8 with value 1 copies the selected block from the array to memory (`mem_we`=1). Value 2 copies memory into the array (`mem_we`=0). Any other value changes nothing and starts no transfer.
- R4: A transfer makes exactly 16 handshakes at addresses base, base+4, base+8 and so on, in ascending order. Under back-pressure `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` hold steady.
- R5: Status bit 0 (busy) reads 1 from the edge that accepts a command until the edge of the last handshake. `mem_valid` is only high while busy.
- R6: At the last handshake, status bit 1 (done) and `irq` are set. `irq` stays high until any write to offset 0xC, which clears both `irq` and done. If completion and an acknowledge fall in the same cycle, completion wins.
- R7: A command with a block number of 8 or more starts no transfer and sets status bit 2 (error). It leaves `irq` low.
- R8: While busy, a valid command is ignored and sets the error bit. Writes to the block-number and address registers are also ignored.
- R9: An accepted command clears the error and done bits.
- R10: Data copied into a block is kept and is returned word for word, in order, when that block is later copied out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = register write, 0 = read |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational |
| mem_valid | output | 1 | Master port request valid |
| mem_ready | input | 1 | Memory accepts the current word |
| mem_we | output | 1 | 1 = write to memory, 0 = read from memory |
| mem_addr | output | 32 | Byte address of the current word |
| mem_wdata | output | 32 | Word written to memory |
| mem_rdata | input | 32 | Word read from memory, valid with `mem_ready` |
| irq | output | 1 | Completion interrupt, level |

## Verification
Register writes take effect at the clock edge that samples them, and register reads are combinational. The bench therefore reads status at the falling edge right after a command. By then busy or error must already show. Completion is due at the edge of the sixteenth accepted handshake, so `irq` and done are polled at falling edges and must appear with no further delay. Each handshake is checked at the edge it occurs on, against the expected base address, index and word. The bench drives `mem_ready` randomly, so this is exercised under varying back-pressure.

// File: rtl/blk_pkg.sv
package blk_pkg;
  // register byte offsets
  localparam int unsigned OFF_BLK  = 'h00;
  localparam int unsigned OFF_ADDR = 'h04;
  localparam int unsigned OFF_CMD  = 'h08;
  localparam int unsigned OFF_ACK  = 'h0C;
  localparam int unsigned OFF_STAT = 'h10;

  // command codes
  localparam int unsigned CMD_TO_MEM   = 1;
  localparam int unsigned CMD_FROM_MEM = 2;

  typedef enum logic {XS_IDLE, XS_RUN} xfer_state_e;
endpackage

// File: rtl/blk_array.sv
module blk_array #(
  parameter int WORD_W    = 32,
  parameter int NUM_BLKS  = 8,
  parameter int BLK_WORDS = 16,
  localparam int BI_W     = $clog2(NUM_BLKS),
  localparam int IDX_W    = $clog2(BLK_WORDS),
  localparam int DEPTH    = NUM_BLKS * BLK_WORDS
) (
  input  logic              clk,
  input  logic [BI_W-1:0]   blk_sel,
  input  logic [IDX_W-1:0]  word_idx,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] store [DEPTH];
  logic [BI_W+IDX_W-1:0] loc;

  assign loc     = {blk_sel, word_idx};
  assign rd_data = store[loc];

  always_ff @(posedge clk) begin
    if (wr_en) store[loc] <= wr_data;
  end
endmodule

// File: rtl/blk_regs.sv
module blk_regs
  import blk_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int REG_AW    = 5,
  parameter int BLK_REG_W = 8,
  parameter int NUM_BLKS  = 8,
  localparam int BI_W     = $clog2(NUM_BLKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              xfer_done,
  output logic              start,
  output logic              start_to_mem,
  output logic [BI_W-1:0]   blk_sel,
  output logic [WORD_W-1:0] base_addr,
  output logic              irq
);
  logic [BLK_REG_W-1:0] blk_q;
  logic [WORD_W-1:0]    addr_q;
  logic done_q, err_q, irq_q;
  logic wr, cmd_wr, code_ok, in_range;

  assign wr       = bus_sel && bus_we;
  assign cmd_wr   = wr && (bus_addr == REG_AW'(OFF_CMD));
  assign code_ok  = (bus_wdata == WORD_W'(CMD_TO_MEM)) ||
                    (bus_wdata == WORD_W'(CMD_FROM_MEM));
  assign in_range = blk_q < BLK_REG_W'(NUM_BLKS);
  assign start        = cmd_wr && code_ok && !busy && in_range;
  assign start_to_mem = (bus_wdata == WORD_W'(CMD_TO_MEM));
  assign blk_sel      = blk_q[BI_W-1:0];
  assign base_addr    = addr_q;
  assign irq          = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q  <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr && !busy && bus_addr == REG_AW'(OFF_BLK))
        blk_q <= bus_wdata[BLK_REG_W-1:0];
      if (wr && !busy && bus_addr == REG_AW'(OFF_ADDR))
        addr_q <= bus_wdata;
      if (cmd_wr && code_ok)
        err_q <= busy || !in_range;
      if (xfer_done) begin
        done_q <= 1'b1;
        irq_q  <= 1'b1;
      end else if (wr && bus_addr == REG_AW'(OFF_ACK)) begin
        done_q <= 1'b0;
        irq_q  <= 1'b0;
      end else if (start) begin
        done_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == REG_AW'(OFF_BLK))
      bus_rdata = {{(WORD_W-BLK_REG_W){1'b0}}, blk_q};
    else if (bus_addr == REG_AW'(OFF_ADDR))
      bus_rdata = addr_q;
    else if (bus_addr == REG_AW'(OFF_STAT))
      bus_rdata = {{(WORD_W-3){1'b0}}, err_q, done_q, busy};
  end
endmodule

// File: rtl/blk_xfer.sv
module blk_xfer
  import blk_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 16,
  localparam int IDX_W    = $clog2(BLK_WORDS),
  localparam int STEP     = WORD_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_to_mem,
  input  logic [WORD_W-1:0] base_addr,
  output logic              busy,
  output logic              xfer_done,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  word_idx,
  input  logic [WORD_W-1:0] arr_rdata,
  output logic              arr_we,
  output logic [WORD_W-1:0] arr_wdata
);
  xfer_state_e       st;
  logic              to_mem_q;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] cur;
  logic hs, last;

  assign mem_valid = (st == XS_RUN);
  assign busy      = (st == XS_RUN);
  assign mem_we    = to_mem_q;
  assign mem_addr  = cur;
  assign mem_wdata = arr_rdata;
  assign hs        = mem_valid && mem_ready;
  assign last      = (idx == IDX_W'(BLK_WORDS - 1));
  assign xfer_done = hs && last;
  assign word_idx  = idx;
  assign arr_we    = hs && !to_mem_q;
  assign arr_wdata = mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= XS_IDLE;
      to_mem_q <= 1'b0;
      idx      <= '0;
      cur      <= '0;
    end else if (st == XS_IDLE) begin
      if (start) begin
        st       <= XS_RUN;
        to_mem_q <= start_to_mem;
        idx      <= '0;
        cur      <= base_addr;
      end
    end else if (hs) begin
      if (last) st <= XS_IDLE;
      idx <= idx + 1'b1;
      cur <= cur + WORD_W'(STEP);
    end
  end
endmodule

// File: rtl/blk_store_ctrl.sv
module blk_store_ctrl #(
  parameter int WORD_W    = 32,
  parameter int REG_AW    = 5,
  parameter int BLK_REG_W = 8,
  parameter int NUM_BLKS  = 8,
  parameter int BLK_WORDS = 16,
  localparam int BI_W     = $clog2(NUM_BLKS),
  localparam int IDX_W    = $clog2(BLK_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              irq
);
  logic              busy_w, done_w, start_w, to_mem_w, arr_we_w;
  logic [BI_W-1:0]   blk_w;
  logic [WORD_W-1:0] base_w, arr_rd_w, arr_wd_w;
  logic [IDX_W-1:0]  idx_w;

  blk_regs #(
    .WORD_W(WORD_W), .REG_AW(REG_AW), .BLK_REG_W(BLK_REG_W), .NUM_BLKS(NUM_BLKS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy_w), .xfer_done(done_w),
    .start(start_w), .start_to_mem(to_mem_w),
    .blk_sel(blk_w), .base_addr(base_w), .irq(irq)
  );

  blk_xfer #(
    .WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS)
  ) u_xfer (
    .clk(clk), .rst_n(rst_n),
    .start(start_w), .start_to_mem(to_mem_w), .base_addr(base_w),
    .busy(busy_w), .xfer_done(done_w),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .word_idx(idx_w), .arr_rdata(arr_rd_w),
    .arr_we(arr_we_w), .arr_wdata(arr_wd_w)
  );

  blk_array #(
    .WORD_W(WORD_W), .NUM_BLKS(NUM_BLKS), .BLK_WORDS(BLK_WORDS)
  ) u_array (
    .clk(clk), .blk_sel(blk_w), .word_idx(idx_w),
    .wr_en(arr_we_w), .wr_data(arr_wd_w), .rd_data(arr_rd_w)
  );
endmodule

// File: rtl/blk_store_chk.sv
module blk_store_chk
  import blk_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [REG_AW-1:0] bus_addr,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [WORD_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              irq,
  input logic              busy,
  input logic              xfer_done
);
  logic ack_wr;
  assign ack_wr = bus_sel && bus_we && (bus_addr == REG_AW'(OFF_ACK));

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                $stable(mem_we) && $stable(mem_wdata));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready |=>
      !mem_valid || (mem_addr == $past(mem_addr) + WORD_W'(WORD_W / 8)));

  // R5
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy);

  // R5
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !busy && irq);

  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ack_wr |=> irq);

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr && !xfer_done |=> !irq);
endmodule

bind blk_store_ctrl blk_store_chk #(.WORD_W(WORD_W), .REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .irq(irq), .busy(busy_w), .xfer_done(done_w)
);

// File: tb/test_blk_store_ctrl.sv
module test_blk_store_ctrl;
  localparam int WORD_W = 32;
  localparam int NBLK   = 8;
  localparam int BWORDS = 16;
  localparam logic [4:0] A_BLK = 5'h00, A_ADDR = 5'h04, A_CMD = 5'h08,
                         A_ACK = 5'h0C, A_STAT = 5'h10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        mem_valid, mem_we, irq;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  blk_store_ctrl i_blk_store_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .irq(irq)
  );

  logic [31:0] sysmem [1024];
  logic [31:0] model [NBLK][BWORDS];
  assign mem_rdata = sysmem[mem_addr[11:2]];

  int n_chk = 0, n_err = 0;
  bit exp_active = 0, exp_we = 0;
  logic [31:0] exp_base = '0;
  int exp_blk = 0, hs_cnt = 0;

  task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // random back-pressure
  always @(negedge clk) mem_ready <= ($urandom % 4) != 0;

  // memory model and per-handshake checks
  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      if (!exp_active) begin
        check_eq("R3/R7/R8 unexpected transfer", 32'd1, 32'd0);
      end else begin
        check_eq("R4 handshake address", mem_addr, exp_base + 32'(hs_cnt * 4));
        check_eq("R3 direction", {31'd0, mem_we}, {31'd0, exp_we});
        if (exp_we && hs_cnt < BWORDS)
          check_eq("R10 word out of storage", mem_wdata, model[exp_blk][hs_cnt]);
        hs_cnt++;
      end
      if (mem_we) sysmem[mem_addr[11:2]] <= mem_wdata;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic setup_xfer(input int cmd, input int blk, input logic [31:0] base);
    wr(A_BLK, 32'(blk));
    wr(A_ADDR, base);
    exp_active = 1; exp_we = (cmd == 1); exp_base = base; exp_blk = blk; hs_cnt = 0;
    if (cmd == 2)
      for (int i = 0; i < BWORDS; i++) model[blk][i] = sysmem[base[11:2] + 10'(i)];
    wr(A_CMD, 32'(cmd));
  endtask

  task automatic wait_irq();
    for (int k = 0; k < 2000; k++) begin
      if (irq) break;
      @(negedge clk);
    end
    check_eq("R6 irq at completion", {31'd0, irq}, 32'd1);
    check_eq("R4 sixteen handshakes", 32'(hs_cnt), 32'(BWORDS));
  endtask

  task automatic ack();
    wr(A_ACK, 32'd0);
    exp_active = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] src, dst;
    int blk;
    void'($urandom(32'd4410));
    for (int i = 0; i < 1024; i++) sysmem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_STAT, v); check_eq("R1 status after reset", v, 32'd0);
    check_eq("R1 irq after reset", {31'd0, irq}, 32'd0);
    check_eq("R1 mem_valid after reset", {31'd0, mem_valid}, 32'd0);

    // R2 register readback
    wr(A_BLK, 32'd3); wr(A_ADDR, 32'h40);
    rd(A_BLK, v);  check_eq("R2 block readback", v, 32'd3);
    rd(A_ADDR, v); check_eq("R2 address readback", v, 32'h40);

    // load block 3 from memory, poke registers while busy
    for (int i = 0; i < BWORDS; i++) sysmem[16 + i] = 32'hA500_0000 + 32'(i);
    setup_xfer(2, 3, 32'h40);
    rd(A_STAT, v); check_eq("R5 busy right after command", v, 32'h1);
    wr(A_BLK, 32'd5);      rd(A_BLK, v);  check_eq("R8 block write ignored while busy", v, 32'd3);
    wr(A_ADDR, 32'h100);   rd(A_ADDR, v); check_eq("R8 address write ignored while busy", v, 32'h40);
    wr(A_CMD, 32'd1);      rd(A_STAT, v); check_eq("R8 command while busy sets error", v, 32'h5);
    wait_irq();
    rd(A_STAT, v); check_eq("R6 done set, busy clear", v, 32'h6);
    repeat (5) @(negedge clk);
    check_eq("R6 irq held without ack", {31'd0, irq}, 32'd1);
    ack();
    check_eq("R6 ack clears irq", {31'd0, irq}, 32'd0);
    rd(A_STAT, v); check_eq("R6 ack clears done", v, 32'h4);

    // copy block 3 out to memory
    setup_xfer(1, 3, 32'h200);
    rd(A_STAT, v); check_eq("R9 accepted command clears error", v, 32'h1);
    wait_irq();
    for (int i = 0; i < BWORDS; i++)
      check_eq("R10 block copied to memory", sysmem[128 + i], 32'hA500_0000 + 32'(i));
    ack();

    // R3 unknown command codes
    wr(A_CMD, 32'd3); wr(A_CMD, 32'd0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check_eq("R3 unknown code starts nothing", {31'd0, mem_valid}, 32'd0);
    end
    rd(A_STAT, v); check_eq("R3 unknown code leaves status", v, 32'd0);

    // R7 out-of-range blocks, including the first one past the end
    wr(A_BLK, 32'd8); wr(A_CMD, 32'd1);
    rd(A_STAT, v); check_eq("R7 block 8 sets error", v, 32'h4);
    wr(A_BLK, 32'd9); wr(A_CMD, 32'd2);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check_eq("R7 no transfer", {31'd0, mem_valid}, 32'd0);
      check_eq("R7 no irq", {31'd0, irq}, 32'd0);
    end
    rd(A_STAT, v); check_eq("R7 error kept", v, 32'h4);

    // random round trips, first and last block included
    for (int it = 0; it < 8; it++) begin
      blk = (it == 0) ? 0 : (it == 1) ? NBLK - 1 : int'($urandom % NBLK);
      src = 32'(($urandom % 12) * 64);
      dst = 32'h800 + 32'(($urandom % 16) * 64);
      for (int i = 0; i < BWORDS; i++) begin
        sysmem[src[11:2] + 10'(i)] = $urandom;
        sysmem[dst[11:2] + 10'(i)] = '0;
      end
      setup_xfer(2, blk, src);
      wait_irq();
      ack();
      setup_xfer(1, blk, dst);
      wait_irq();
      for (int i = 0; i < BWORDS; i++)
        check_eq("R10 round trip word", sysmem[dst[11:2] + 10'(i)], model[blk][i]);
      ack();
    end

    summary();
    $finish;
  end
endmodule